// File: doc/BRIEF.md
# Camera capture decimation filter

This block sits between a parallel camera port and a downstream packing stage. It oversamples the camera pixel clock, VSYNC, HSYNC and pixel data in the system clock domain. It acts on each pixel at the chosen pixel-clock edge. It follows frame and line boundaries using programmable sync polarities. It thins the stream at three independent levels: items within a line, lines within a frame, and whole frames. Each level has its own selection pattern and starting phase. Kept items leave on a simple valid/data stream.

Capture is controlled by a start pulse and a stop pulse. In continuous mode capture stays on until it is stopped. In snapshot mode the block waits for the next frame start, delivers one frame and then turns its own capture enable off. The block also gives a one-cycle start-of-frame pulse, an end-of-line pulse for every delivered line, a frame-complete pulse and two status levels showing blanking. The configuration inputs are latched only while the block is idle, so a setting never changes in the middle of a frame.

Top module: `cam_decim`

## Requirements
- R1: A pixel is taken when the sampled pixel clock makes a transition to the level `cfg_edge_rise` (1 = rising edge, 0 = falling edge). Data, VSYNC and HSYNC values seen at the other edge are never used.
- R2: VSYNC or HSYNC is active when its level equals `cfg_vs_pol` or `cfg_hs_pol` respectively (1 = active high, 0 = active low). `between_frames` and `between_lines` are 1 while the matching sync was inactive at the last pixel, and both are 1 after reset. An item is a pixel at which both syncs are active.
- R3: The item index d within a line is counted from 0 and then offset by the phase: d = (index - `cfg_byte_phase`) mod 4. `cfg_byte_sel` selects which items are kept: 0 keeps every item, 1 keeps items where d is even, 2 keeps items where d = 0, and 3 keeps items where d < 2.
- R4: The item index restarts at 0 at every line start, which is HSYNC becoming active while VSYNC is active. An odd-length line therefore does not shift the pattern of the next line.
- R5: Lines are numbered from 0 at each frame start. When `cfg_line_sel` = 0 every line is kept. When it is 1, only lines whose number parity equals `cfg_line_phase` are kept.
- R6: Frames are counted from 0 starting at the capture start. `cfg_frame_rate` 0 keeps every frame, 1 keeps the even-numbered frames, and 2 or 3 keeps frames whose number is a multiple of 4.
- R7: `sof_pulse` is high for one cycle on every inactive-to-active VSYNC transition, whether or not capture is enabled.
- R8: `eol_pulse` is high for one cycle when a kept line of a captured frame ends, which is HSYNC going inactive.
- R9: `frame_done` is high for one cycle when VSYNC goes inactive at the end of a captured frame.
- R10: With `cfg_snapshot` = 1, a `cap_start` pulse arms capture. The next frame start begins one frame, and `cap_en` falls in the same cycle that `frame_done` rises. No later frame is delivered.
- R11: `cap_en` rises only in the cycle after a `cap_start` pulse. In continuous mode it stays high until a `cap_stop` pulse. After a stop, the frame in progress is still delivered to its end, and later frames are not delivered.
- R12: Configuration inputs are latched only while capture is off and no frame is being delivered. Changes made during capture have no effect on the output.
- R13: Enabling capture in the middle of a frame delivers nothing until the next frame start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| pix_clk | input | 1 | Camera pixel clock, oversampled |
| pix_vsync | input | 1 | Camera frame sync |
| pix_hsync | input | 1 | Camera line sync |
| pix_data | input | DATA_W | Camera pixel data |
| cfg_edge_rise | input | 1 | Pixel clock edge select: 1 rising, 0 falling |
| cfg_vs_pol | input | 1 | VSYNC active level |
| cfg_hs_pol | input | 1 | HSYNC active level |
| cfg_byte_sel | input | 2 | Item selection pattern |
| cfg_byte_phase | input | 1 | Item pattern phase |
| cfg_line_sel | input | 1 | 0 all lines, 1 one line in two |
| cfg_line_phase | input | 1 | Line parity kept |
| cfg_frame_rate | input | 2 | Frame keep rate |
| cfg_snapshot | input | 1 | 1 single frame, 0 continuous |
| cap_start | input | 1 | Pulse: enable capture |
| cap_stop | input | 1 | Pulse: disable capture |
| cap_en | output | 1 | Capture enable state |
| out_valid | output | 1 | Kept item valid |
| out_data | output | DATA_W | Kept item |
| sof_pulse | output | 1 | Start of frame pulse |
| eol_pulse | output | 1 | End of kept line pulse |
| frame_done | output | 1 | Captured frame complete pulse |
| between_frames | output | 1 | VSYNC inactive at last pixel |
| between_lines | output | 1 | HSYNC inactive at last pixel |

## Verification
The bench puts inverted data on the pixel bus during the inactive pixel-clock phase. A design that samples on the wrong edge, or applies the wrong polarity, delivers bit-flipped items or sees frames at the wrong time. Lines have an odd length and there are runs with each phase, so a design that does not restart the item index per line, or applies the phase offset wrongly, drops or keeps the wrong items. Frames are started both together with and before the first line. Capture is started in the middle of a frame, stopped in the middle of a frame, run in snapshot mode, and restarted after a frame-rate run. Each of these exposes a design that does not reset the frame counter, leaks a partial frame, or fails to clear its own enable. A configuration change during capture must leave the output pattern unchanged.

// File: rtl/cam_decim_pkg.sv
package cam_decim_pkg;

    localparam int unsigned BIDX_W = 2;
    localparam int unsigned FCNT_W = 2;

    typedef enum logic [1:0] {
        BSEL_ALL     = 2'd0,
        BSEL_HALF    = 2'd1,
        BSEL_QUARTER = 2'd2,
        BSEL_PAIR    = 2'd3
    } bsel_e;

    typedef enum logic [1:0] {
        FRATE_ALL   = 2'd0,
        FRATE_HALF  = 2'd1,
        FRATE_QTR   = 2'd2,
        FRATE_QTR_B = 2'd3
    } frate_e;

    typedef struct packed {
        logic   edge_rise;
        logic   vs_pol;
        logic   hs_pol;
        bsel_e  bsel;
        logic   bphase;
        logic   lsel;
        logic   lphase;
        frate_e frate;
        logic   snapshot;
    } cfg_t;

    typedef struct packed {
        logic sof;
        logic lstart;
        logic lend;
        logic fend;
        logic item;
    } sync_ev_t;

    function automatic logic keep_byte(bsel_e m, logic ph, logic [BIDX_W-1:0] idx);
        logic [BIDX_W-1:0] d;
        logic k;
        d = idx - BIDX_W'(ph);
        case (m)
            BSEL_ALL:     k = 1'b1;
            BSEL_HALF:    k = ~d[0];
            BSEL_QUARTER: k = (d == '0);
            default:      k = ~d[1];
        endcase
        return k;
    endfunction

    function automatic logic keep_line(logic sel, logic ph, logic par);
        return (!sel) || (par == ph);
    endfunction

    function automatic logic keep_frame(frate_e r, logic [FCNT_W-1:0] c);
        logic k;
        case (r)
            FRATE_ALL:  k = 1'b1;
            FRATE_HALF: k = ~c[0];
            default:    k = (c == '0);
        endcase
        return k;
    endfunction

endpackage

// File: rtl/cam_decim_sampler.sv
module cam_decim_sampler #(
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              pix_clk,
    input  logic              pix_vsync,
    input  logic              pix_hsync,
    input  logic [DATA_W-1:0] pix_data,
    input  logic              edge_rise,
    input  logic              vs_pol,
    input  logic              hs_pol,
    output logic              smp_ev,
    output logic              smp_vs_act,
    output logic              smp_hs_act,
    output logic [DATA_W-1:0] smp_data
);

    logic pclk_r, pclk_d, vs_r, hs_r;
    logic [DATA_W-1:0] data_r;

    always_ff @(posedge clk) begin
        if (rst) begin
            pclk_r <= 1'b0;
            pclk_d <= 1'b0;
            vs_r   <= 1'b0;
            hs_r   <= 1'b0;
            data_r <= '0;
        end else begin
            pclk_r <= pix_clk;
            pclk_d <= pclk_r;
            vs_r   <= pix_vsync;
            hs_r   <= pix_hsync;
            data_r <= pix_data;
        end
    end

    // an edge is a change of the sampled clock towards the selected level
    assign smp_ev     = (pclk_r != pclk_d) && (pclk_r == edge_rise);
    assign smp_vs_act = (vs_r == vs_pol);
    assign smp_hs_act = (hs_r == hs_pol);
    assign smp_data   = data_r;

endmodule

// File: rtl/cam_decim_sync.sv
module cam_decim_sync
    import cam_decim_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     ev,
    input  logic     vs_act,
    input  logic     hs_act,
    output sync_ev_t sev,
    output logic     sof_pulse,
    output logic     between_frames,
    output logic     between_lines
);

    logic vs_q, hs_q;

    always_comb begin
        sev.sof    = ev && vs_act && !vs_q;
        sev.lstart = ev && vs_act && hs_act && !hs_q;
        sev.lend   = ev && vs_q && hs_q && !hs_act;
        sev.fend   = ev && vs_q && !vs_act;
        sev.item   = ev && vs_act && hs_act;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            vs_q           <= 1'b0;
            hs_q           <= 1'b0;
            sof_pulse      <= 1'b0;
            between_frames <= 1'b1;
            between_lines  <= 1'b1;
        end else begin
            sof_pulse <= sev.sof;
            if (ev) begin
                vs_q           <= vs_act;
                hs_q           <= hs_act;
                between_frames <= !vs_act;
                between_lines  <= !hs_act;
            end
        end
    end

endmodule

// File: rtl/cam_decim_ctl.sv
module cam_decim_ctl
    import cam_decim_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  cfg_t cfg_in,
    input  logic cap_start,
    input  logic cap_stop,
    input  logic ev_sof,
    input  logic ev_fend,
    output cfg_t cfg_q,
    output logic cap_en,
    output logic frame_go,
    output logic frame_act,
    output logic frame_done
);

    logic [FCNT_W-1:0] fcnt;
    logic              keep_f;

    assign keep_f   = keep_frame(cfg_q.frate, fcnt);
    // a frame starting at this pixel is already live for its first item
    assign frame_go = ev_sof ? (cap_en && keep_f) : frame_act;

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q      <= '0;
            cap_en     <= 1'b0;
            frame_act  <= 1'b0;
            frame_done <= 1'b0;
            fcnt       <= '0;
        end else begin
            frame_done <= ev_fend && frame_act;
            if (!cap_en && !frame_act)
                cfg_q <= cfg_in;

            if (ev_sof) begin
                frame_act <= cap_en && keep_f;
                if (cap_en)
                    fcnt <= fcnt + 1'b1;
            end else if (ev_fend) begin
                frame_act <= 1'b0;
            end

            if (cap_start && !cap_en) begin
                cap_en <= 1'b1;
                fcnt   <= '0;
            end else if (cap_stop) begin
                cap_en <= 1'b0;
            end else if (ev_fend && frame_act && cfg_q.snapshot) begin
                cap_en <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/cam_decim_sel.sv
module cam_decim_sel
    import cam_decim_pkg::*;
#(
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ev_item,
    input  logic              ev_sof,
    input  logic              ev_lstart,
    input  logic              ev_lend,
    input  logic [DATA_W-1:0] in_data,
    input  logic              frame_go,
    input  logic              frame_act,
    input  bsel_e             bsel,
    input  logic              bphase,
    input  logic              lsel,
    input  logic              lphase,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_data,
    output logic              eol_pulse
);

    logic [BIDX_W-1:0] bidx, idx_eff;
    logic              lpar, par_eff, take;

    always_comb begin
        idx_eff = ev_lstart ? '0 : bidx;
        par_eff = ev_sof ? 1'b0 : lpar;
        take    = ev_item && frame_go
                  && keep_line(lsel, lphase, par_eff)
                  && keep_byte(bsel, bphase, idx_eff);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            bidx      <= '0;
            lpar      <= 1'b0;
            out_valid <= 1'b0;
            out_data  <= '0;
            eol_pulse <= 1'b0;
        end else begin
            out_valid <= take;
            if (take)
                out_data <= in_data;
            eol_pulse <= ev_lend && frame_act && keep_line(lsel, lphase, lpar);
            if (ev_sof)
                lpar <= 1'b0;
            else if (ev_lend)
                lpar <= ~lpar;
            if (ev_item)
                bidx <= idx_eff + 1'b1;
        end
    end

endmodule

// File: rtl/cam_decim.sv
module cam_decim
    import cam_decim_pkg::*;
#(
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              pix_clk,
    input  logic              pix_vsync,
    input  logic              pix_hsync,
    input  logic [DATA_W-1:0] pix_data,
    input  logic              cfg_edge_rise,
    input  logic              cfg_vs_pol,
    input  logic              cfg_hs_pol,
    input  logic [1:0]        cfg_byte_sel,
    input  logic              cfg_byte_phase,
    input  logic              cfg_line_sel,
    input  logic              cfg_line_phase,
    input  logic [1:0]        cfg_frame_rate,
    input  logic              cfg_snapshot,
    input  logic              cap_start,
    input  logic              cap_stop,
    output logic              cap_en,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_data,
    output logic              sof_pulse,
    output logic              eol_pulse,
    output logic              frame_done,
    output logic              between_frames,
    output logic              between_lines
);

    cfg_t              cfg_in, cfg_q;
    sync_ev_t          sev;
    logic              smp_ev, smp_vs_act, smp_hs_act;
    logic [DATA_W-1:0] smp_data;
    logic              frame_go, frame_act;

    always_comb begin
        cfg_in.edge_rise = cfg_edge_rise;
        cfg_in.vs_pol    = cfg_vs_pol;
        cfg_in.hs_pol    = cfg_hs_pol;
        cfg_in.bsel      = bsel_e'(cfg_byte_sel);
        cfg_in.bphase    = cfg_byte_phase;
        cfg_in.lsel      = cfg_line_sel;
        cfg_in.lphase    = cfg_line_phase;
        cfg_in.frate     = frate_e'(cfg_frame_rate);
        cfg_in.snapshot  = cfg_snapshot;
    end

    cam_decim_sampler #(.DATA_W(DATA_W)) u_smp (
        .clk        (clk),
        .rst        (rst),
        .pix_clk    (pix_clk),
        .pix_vsync  (pix_vsync),
        .pix_hsync  (pix_hsync),
        .pix_data   (pix_data),
        .edge_rise  (cfg_q.edge_rise),
        .vs_pol     (cfg_q.vs_pol),
        .hs_pol     (cfg_q.hs_pol),
        .smp_ev     (smp_ev),
        .smp_vs_act (smp_vs_act),
        .smp_hs_act (smp_hs_act),
        .smp_data   (smp_data)
    );

    cam_decim_sync u_sync (
        .clk            (clk),
        .rst            (rst),
        .ev             (smp_ev),
        .vs_act         (smp_vs_act),
        .hs_act         (smp_hs_act),
        .sev            (sev),
        .sof_pulse      (sof_pulse),
        .between_frames (between_frames),
        .between_lines  (between_lines)
    );

    cam_decim_ctl u_ctl (
        .clk        (clk),
        .rst        (rst),
        .cfg_in     (cfg_in),
        .cap_start  (cap_start),
        .cap_stop   (cap_stop),
        .ev_sof     (sev.sof),
        .ev_fend    (sev.fend),
        .cfg_q      (cfg_q),
        .cap_en     (cap_en),
        .frame_go   (frame_go),
        .frame_act  (frame_act),
        .frame_done (frame_done)
    );

    cam_decim_sel #(.DATA_W(DATA_W)) u_sel (
        .clk       (clk),
        .rst       (rst),
        .ev_item   (sev.item),
        .ev_sof    (sev.sof),
        .ev_lstart (sev.lstart),
        .ev_lend   (sev.lend),
        .in_data   (smp_data),
        .frame_go  (frame_go),
        .frame_act (frame_act),
        .bsel      (cfg_q.bsel),
        .bphase    (cfg_q.bphase),
        .lsel      (cfg_q.lsel),
        .lphase    (cfg_q.lphase),
        .out_valid (out_valid),
        .out_data  (out_data),
        .eol_pulse (eol_pulse)
    );

endmodule

// File: rtl/cam_decim_chk.sv
module cam_decim_chk (
    input logic clk,
    input logic rst,
    input logic cap_start,
    input logic cap_en,
    input logic out_valid,
    input logic sof_pulse,
    input logic eol_pulse,
    input logic frame_done,
    input logic between_frames,
    input logic between_lines,
    input logic snap_q
);

    p_item_in_line_r3: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (!between_frames && !between_lines));

    p_sof_single_r7: assert property (@(posedge clk) disable iff (rst)
        sof_pulse |=> !sof_pulse);

    p_sof_active_r7: assert property (@(posedge clk) disable iff (rst)
        sof_pulse |-> !between_frames);

    p_eol_at_blank_r8: assert property (@(posedge clk) disable iff (rst)
        eol_pulse |-> between_lines);

    p_done_at_blank_r9: assert property (@(posedge clk) disable iff (rst)
        frame_done |-> between_frames);

    p_sof_done_excl_r9: assert property (@(posedge clk) disable iff (rst)
        $onehot0({sof_pulse, frame_done}));

    p_snap_clear_r10: assert property (@(posedge clk) disable iff (rst)
        (frame_done && snap_q) |-> !cap_en);

    p_en_from_start_r11: assert property (@(posedge clk) disable iff (rst)
        $rose(cap_en) |-> $past(cap_start));

endmodule

bind cam_decim cam_decim_chk u_chk (
    .clk            (clk),
    .rst            (rst),
    .cap_start      (cap_start),
    .cap_en         (cap_en),
    .out_valid      (out_valid),
    .sof_pulse      (sof_pulse),
    .eol_pulse      (eol_pulse),
    .frame_done     (frame_done),
    .between_frames (between_frames),
    .between_lines  (between_lines),
    .snap_q         (cfg_q.snapshot)
);

// File: tb/sim_cam_decim.sv
module sim_cam_decim;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #10 clk = ~clk;

    logic       pix_clk = 1'b0, pix_vsync = 1'b0, pix_hsync = 1'b0;
    logic [7:0] pix_data = 8'h00;
    logic       cfg_edge_rise = 1'b1, cfg_vs_pol = 1'b1, cfg_hs_pol = 1'b1;
    logic [1:0] cfg_byte_sel = 2'd0, cfg_frame_rate = 2'd0;
    logic       cfg_byte_phase = 1'b0, cfg_line_sel = 1'b0, cfg_line_phase = 1'b0;
    logic       cfg_snapshot = 1'b0, cap_start = 1'b0, cap_stop = 1'b0;
    logic       cap_en, out_valid, sof_pulse, eol_pulse, frame_done;
    logic       between_frames, between_lines;
    logic [7:0] out_data;

    cam_decim #(.DATA_W(8)) u0 (.*);

    int checks = 0, errors = 0;
    bit finished = 0;

    // reference model state
    int m_edge = 1, m_vpol = 1, m_hpol = 1, m_bsel = 0, m_bph = 0;
    int m_lsel = 0, m_lph = 0, m_frate = 0, m_snap = 0;
    int m_capen = 0, m_fcnt = 0, m_fact = 0, m_lpar = 0, m_bidx = 0;
    int m_vq = 0, m_hq = 0;
    int m_sof = 0, m_eol = 0, m_done = 0;
    int o_sof = 0, o_eol = 0, o_done = 0;
    logic [7:0] exp_q[$];
    logic [7:0] dat = 8'h10;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic bit m_keep_item(int idx);
        int d = (idx - m_bph + 4) % 4;
        if (m_bsel == 0) return 1;
        if (m_bsel == 1) return (d % 2) == 0;
        if (m_bsel == 2) return d == 0;
        return d < 2;
    endfunction

    function automatic bit m_keep_line(int par);
        return (m_lsel == 0) || (par == m_lph);
    endfunction

    function automatic bit m_keep_frame(int n);
        if (m_frate == 0) return 1;
        if (m_frate == 1) return (n % 2) == 0;
        return (n % 4) == 0;
    endfunction

    task automatic model_step(input int va, input int ha, input logic [7:0] d);
        int idx;
        int par;
        par = m_lpar;
        if (va && !m_vq) begin
            m_sof++;
            m_fact = m_capen ? int'(m_keep_frame(m_fcnt)) : 0;
            if (m_capen) m_fcnt++;
            m_lpar = 0;
            par = 0;
        end
        if (va && ha) begin
            idx = (!m_hq) ? 0 : m_bidx;
            if (m_fact && m_keep_line(par) && m_keep_item(idx)) exp_q.push_back(d);
            m_bidx = (idx + 1) % 4;
        end
        if (m_vq && m_hq && !ha) begin
            if (m_fact && m_keep_line(m_lpar)) m_eol++;
            m_lpar = 1 - m_lpar;
        end
        if (m_vq && !va) begin
            if (m_fact) begin
                m_done++;
                if (m_snap) m_capen = 0;
            end
            m_fact = 0;
        end
        m_vq = va;
        m_hq = ha;
    endtask

    // one pixel: junk on the inactive edge, real values before the active edge
    task automatic pix(input int va, input int ha, input logic [7:0] d);
        @(negedge clk);
        pix_clk  = (m_edge == 0);
        pix_data = ~d;
        @(negedge clk);
        @(negedge clk);
        pix_data  = d;
        pix_vsync = (va != 0) ? m_vpol[0] : ~m_vpol[0];
        pix_hsync = (ha != 0) ? m_hpol[0] : ~m_hpol[0];
        @(negedge clk);
        pix_clk = (m_edge != 0);
        @(negedge clk);
        model_step(va, ha, d);
    endtask

    task automatic head(input int lead);
        pix(0, 0, 8'h00);
        pix(0, 0, 8'h00);
        if (lead != 0) pix(1, 0, 8'h00);
    endtask

    task automatic line(input int nb);
        for (int b = 0; b < nb; b++) begin
            pix(1, 1, dat);
            dat = dat + 8'd1;
        end
        pix(1, 0, 8'h00);
    endtask

    task automatic tail();
        pix(0, 0, 8'h00);
        pix(0, 0, 8'h00);
    endtask

    task automatic frame(input int nl, input int nb, input int lead);
        head(lead);
        for (int l = 0; l < nl; l++) line(nb);
        tail();
    endtask

    task automatic set_cfg(input int e, input int vp, input int hp, input int bs, input int bp,
                           input int ls, input int lp, input int fr, input int sn);
        @(negedge clk);
        m_edge = e; m_vpol = vp; m_hpol = hp; m_bsel = bs; m_bph = bp;
        m_lsel = ls; m_lph = lp; m_frate = fr; m_snap = sn;
        cfg_edge_rise = e[0]; cfg_vs_pol = vp[0]; cfg_hs_pol = hp[0];
        cfg_byte_sel = bs[1:0]; cfg_byte_phase = bp[0]; cfg_line_sel = ls[0];
        cfg_line_phase = lp[0]; cfg_frame_rate = fr[1:0]; cfg_snapshot = sn[0];
    endtask

    task automatic start();
        @(negedge clk);
        cap_start = 1'b1;
        @(negedge clk);
        cap_start = 1'b0;
        m_capen = 1;
        m_fcnt = 0;
    endtask

    task automatic stop();
        @(negedge clk);
        cap_stop = 1'b1;
        @(negedge clk);
        cap_stop = 1'b0;
        m_capen = 0;
    endtask

    task automatic end_test(input string tag);
        repeat (12) @(negedge clk);
        chk(exp_q.size() == 0, {tag, " missing items"}, exp_q.size(), 0);
        chk(o_sof == m_sof, "R7 sof count", o_sof, m_sof);
        chk(o_eol == m_eol, "R8 eol count", o_eol, m_eol);
        chk(o_done == m_done, "R9 frame_done count", o_done, m_done);
        chk(cap_en == m_capen[0], "R11 cap_en state", cap_en, m_capen);
        exp_q.delete();
        o_sof = 0; o_eol = 0; o_done = 0;
        m_sof = 0; m_eol = 0; m_done = 0;
    endtask

    // output monitor, compared on every clock
    always @(negedge clk) begin
        if (!rst) begin
            if (sof_pulse) o_sof++;
            if (eol_pulse) o_eol++;
            if (frame_done) o_done++;
            if (out_valid) begin
                if (exp_q.size() == 0) begin
                    chk(0, "R3 unexpected item", out_data, -1);
                end else begin
                    logic [7:0] e;
                    e = exp_q.pop_front();
                    chk(out_data == e, "R3 item value", out_data, e);
                end
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // reset state
        chk(cap_en == 1'b0, "R11 reset cap_en", cap_en, 0);
        chk(out_valid == 1'b0, "R3 reset out_valid", out_valid, 0);
        chk(between_frames == 1'b1, "R2 reset between_frames", between_frames, 1);
        chk(between_lines == 1'b1, "R2 reset between_lines", between_lines, 1);

        // R1 R7 R8 R9 R11: continuous, rising edge, all kept, both frame-start styles
        set_cfg(1, 1, 1, 0, 0, 0, 0, 0, 0);
        start();
        frame(3, 6, 1);
        frame(2, 5, 0);
        stop();
        end_test("R1");

        // R3 R4: every item pattern and phase, odd line length
        for (int m = 1; m < 4; m++) begin
            for (int p = 0; p < 2; p++) begin
                set_cfg(1, 1, 1, m, p, 0, 0, 0, 0);
                start();
                frame(3, 7, 1);
                stop();
                end_test("R4");
            end
        end

        // R5: one line in two, both phases
        for (int p = 0; p < 2; p++) begin
            set_cfg(1, 1, 1, 0, 0, 1, p, 0, 0);
            start();
            frame(5, 3, 1);
            stop();
            end_test("R5");
        end

        // R6: frame rates, and counter reset on restart
        set_cfg(1, 1, 1, 0, 0, 0, 0, 1, 0);
        start();
        for (int f = 0; f < 5; f++) frame(1, 4, 1);
        stop();
        start();
        for (int f = 0; f < 2; f++) frame(1, 4, 1);
        stop();
        end_test("R6");
        set_cfg(1, 1, 1, 1, 1, 0, 0, 2, 0);
        start();
        for (int f = 0; f < 6; f++) frame(1, 4, 1);
        stop();
        end_test("R6");

        // R10: snapshot waits for a frame start, delivers one frame, clears enable
        set_cfg(1, 1, 1, 0, 0, 0, 0, 0, 1);
        start();
        repeat (4) @(negedge clk);
        chk(cap_en == 1'b1, "R10 armed before frame", cap_en, 1);
        frame(2, 4, 1);
        repeat (3) @(negedge clk);
        chk(cap_en == 1'b0, "R10 enable cleared", cap_en, 0);
        frame(2, 4, 1);
        end_test("R10");

        // R1 R2: falling edge, active-low syncs, status levels
        set_cfg(0, 0, 0, 0, 0, 0, 0, 0, 0);
        start();
        head(1);
        pix(1, 1, dat);
        dat = dat + 8'd1;
        repeat (2) @(negedge clk);
        chk(between_lines == 1'b0, "R2 in line", between_lines, 0);
        chk(between_frames == 1'b0, "R2 in frame", between_frames, 0);
        line(3);
        repeat (2) @(negedge clk);
        chk(between_lines == 1'b1, "R2 line blank", between_lines, 1);
        line(4);
        tail();
        repeat (2) @(negedge clk);
        chk(between_frames == 1'b1, "R2 frame blank", between_frames, 1);
        stop();
        end_test("R2");

        // R13: enable in the middle of a frame
        set_cfg(1, 1, 1, 0, 0, 0, 0, 0, 0);
        head(1);
        line(4);
        start();
        line(4);
        tail();
        frame(1, 3, 1);
        stop();
        end_test("R13");

        // R11: stop in the middle of a frame finishes that frame only
        start();
        head(1);
        line(4);
        stop();
        line(4);
        tail();
        frame(1, 4, 1);
        end_test("R11");

        // R12: configuration change during capture has no effect
        set_cfg(1, 1, 1, 0, 0, 0, 0, 0, 0);
        start();
        @(negedge clk);
        cfg_byte_sel = 2'd2;
        cfg_line_sel = 1'b1;
        frame(2, 5, 1);
        stop();
        end_test("R12");

        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule